// File: doc/BRIEF.md
# Paired PWM Generator with Edge-Triggered Fault Trip

Two PWM outputs run from one shared up-counter with a programmable period. Each output has its own duty compare value and its own idle level. When the counter is below a channel's duty value, that channel is in its active state, which is the inverse of its idle level. Otherwise the channel sits at its idle level. The counter runs from zero up to the period value and then wraps, so one PWM cycle lasts period+1 clocks. Counting happens only while the run input is high.

A fault-trip unit watches one of two external pins. Each pin passes through a two-flop synchronizer. A configurable edge on the selected pin trips the unit, but only while the paired mode bit is set. A trip latches a sticky status flag and emits a one-cycle interrupt pulse. It also clears and holds the counter, and it drives both outputs to their idle levels in the same clock. Software releases the trip by writing a one to the clear bit of the control register. Counting then resumes from zero.

Configuration goes through a simple write port with a 2-bit address. Address 0 is control, address 1 is the period, address 2 is the channel 0 duty and address 3 is the channel 1 duty. The data width CNT_W must be at least 8.

Top module: `pwm_trip_pair`

## Requirements
- R1: After reset the status flag and the interrupt are 0, and both outputs are 0 (the idle bits reset to 0).
- R2: While running, the counter steps 0,1,...,period and then returns to 0, so each output repeats every period+1 clocks.
- R3: Channel c drives the inverse of its idle bit (control bit 4 for channel 0, bit 5 for channel 1) while the counter is below its duty value, and the idle bit otherwise. A duty of 0 keeps the channel idle.
- R4: While the run input is low, the counter is held at 0 and both outputs sit at their idle levels.
- R5: The control edge field, bits 3:2, selects the trip condition: 2'b10 is a rising edge, 2'b01 a falling edge, 2'b11 either edge, and 2'b00 disables the trip.
- R6: Control bit 1 selects the trip pin: 0 for pin 0, 1 for pin 1. Edges on the unselected pin do nothing.
- R7: Trips occur only while the paired mode bit, control bit 0, is 1. When it is 0, pin edges are ignored and the PWM keeps running.
- R8: A qualifying pin change sets the status flag and gives a single-cycle interrupt pulse. Both are visible after the third rising clock edge that follows the change (two sync stages plus detection).
- R9: While the status flag is set, the counter is 0 and both outputs are at their idle levels, even with run high. Both outputs change in the same cycle.
- R10: Writing control with bit 6 = 1 clears the flag, and writing bit 6 = 0 leaves it set. After a clear, the counter is 0 in the first cycle and counts on from there.
- R11: If a trip and a clear write fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 period, 2 duty 0, 3 duty 1 |
| wr_data_i | input | CNT_W | Write data |
| run_i | input | 1 | Counter run enable |
| trip_pin_i | input | 2 | External fault-trip pins, asynchronous |
| pwm_o | output | 2 | PWM outputs, channel 0 in bit 0 |
| stop_flag_o | output | 1 | Sticky trip status flag |
| stop_irq_o | output | 1 | One-cycle trip interrupt pulse |

## Verification
A fresh trip and a software clear of the status flag can land in the same cycle, and the trip must take priority. The bench provokes this with a rising edge on the selected pin while the flag is still set from an earlier trip. It times the clear write to be sampled at exactly the clock edge where the synchronized edge is detected. The flag is expected to remain high, with a new interrupt pulse, after that edge. An ordinary clear issued later must then release the flag.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_DUTY0  = 2'd2,
    REG_DUTY1  = 2'd3
  } reg_addr_e;

  localparam int CTRL_W   = 6;
  localparam int CTRL_CLR = 6;

  // bit0 pair, bit1 pin_sel, bits3:2 edge_sel, bits5:4 idle levels
  typedef struct packed {
    logic [NCH-1:0] idle;
    logic [1:0]     edge_sel;
    logic           pin_sel;
    logic           pair;
  } ctrl_t;
endpackage

// File: rtl/pwm_trip_sync.sv
module pwm_trip_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/pwm_trip_detect.sv
module pwm_trip_detect (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pin_sync_i,
  input  logic       pin_sel_i,
  input  logic [1:0] edge_sel_i,
  input  logic       enable_i,
  input  logic       clr_i,
  output logic       trip_o,
  output logic       flag_o,
  output logic       irq_o
);
  logic cur, prev_q, rise, fall;

  assign cur  = pin_sel_i ? pin_sync_i[1] : pin_sync_i[0];
  assign rise = cur & ~prev_q;
  assign fall = ~cur & prev_q;
  assign trip_o = enable_i & ((edge_sel_i[1] & rise) | (edge_sel_i[0] & fall));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= cur;
      irq_o  <= trip_o;
      // trip has priority over the write-one clear
      flag_o <= trip_o | (flag_o & ~clr_i);
    end
  end

  assert_flag_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
  assert_trip_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o && clr_i |=> flag_o && irq_o);
  assert_irq_with_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
endmodule

// File: rtl/pwm_trip_counter.sv
module pwm_trip_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (!run_i || halt_i)    cnt_o <= '0;
    else if (cnt_o >= period_i)   cnt_o <= '0;
    else                          cnt_o <= cnt_o + 1'b1;
  end

  assert_run_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_o == '0);
  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !halt_i && cnt_o == period_i |=> cnt_o == '0);
endmodule

// File: rtl/pwm_trip_channel.sv
module pwm_trip_channel #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             idle_i,
  input  logic             enable_i,
  output logic             pwm_o
);
  assign pwm_o = (enable_i && (cnt_i < duty_i)) ? ~idle_i : idle_i;
endmodule

// File: rtl/pwm_trip_pair.sv
module pwm_trip_pair
  import pwm_trip_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             run_i,
  input  logic [1:0]       trip_pin_i,
  output logic [NCH-1:0]   pwm_o,
  output logic             stop_flag_o,
  output logic             stop_irq_o
);
  ctrl_t                     ctrl_q;
  logic [CNT_W-1:0]          period_q;
  logic [NCH-1:0][CNT_W-1:0] duty_q;
  logic [CNT_W-1:0]          cnt;
  logic [1:0]                pin_sync;
  logic                      clr, trip, out_en;
  logic                      unused_wr_bits;

  assign unused_wr_bits = ^wr_data_i[CNT_W-1:CTRL_CLR+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '1;
      duty_q   <= '0;
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(wr_addr_i))
        REG_CTRL:   ctrl_q    <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        REG_PERIOD: period_q  <= wr_data_i;
        REG_DUTY0:  duty_q[0] <= wr_data_i;
        REG_DUTY1:  duty_q[1] <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign clr = wr_en_i && (reg_addr_e'(wr_addr_i) == REG_CTRL) && wr_data_i[CTRL_CLR];

  pwm_trip_sync #(.W(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (trip_pin_i),
    .sync_o  (pin_sync)
  );

  pwm_trip_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_sync_i (pin_sync),
    .pin_sel_i  (ctrl_q.pin_sel),
    .edge_sel_i (ctrl_q.edge_sel),
    .enable_i   (ctrl_q.pair),
    .clr_i      (clr),
    .trip_o     (trip),
    .flag_o     (stop_flag_o),
    .irq_o      (stop_irq_o)
  );

  pwm_trip_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .halt_i   (trip | stop_flag_o),
    .period_i (period_q),
    .cnt_o    (cnt)
  );

  // shared output enable: one signal kills both channels together
  assign out_en = run_i & ~stop_flag_o;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_trip_channel #(.CNT_W(CNT_W)) u_ch (
      .cnt_i    (cnt),
      .duty_i   (duty_q[c]),
      .idle_i   (ctrl_q.idle[c]),
      .enable_i (out_en),
      .pwm_o    (pwm_o[c])
    );
  end

  assert_idle_on_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_flag_o |-> pwm_o == ctrl_q.idle);
  assert_cnt_zero_on_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_flag_o |-> cnt == '0);
  assert_pair_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_flag_o) |-> $past(ctrl_q.pair));
endmodule

// File: tb/test_pwm_trip_pair.sv
module test_pwm_trip_pair;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             run = 1'b0;
  logic [1:0]       pins = '0;
  logic [1:0]       pwm;
  logic             flag, irq;

  int tests = 0;
  int fails = 0;
  logic [7:0] cur_ctrl = '0;

  always #2 clk = ~clk;

  pwm_trip_pair #(.CNT_W(CNT_W)) i_pwm_trip_pair (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .run_i(run), .trip_pin_i(pins),
    .pwm_o(pwm), .stop_flag_o(flag), .stop_irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] mk(bit pair, bit sel, bit [1:0] edg, bit [1:0] idle);
    return {2'b00, idle, edg, sel, pair};
  endfunction

  task automatic set_ctrl(logic [7:0] c);
    cur_ctrl = c;
    wr(2'd0, c);
  endtask

  task automatic clear_flag();
    wr(2'd0, cur_ctrl | 8'h40);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic count_high(int n, output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int i = 0; i < n; i++) begin
      h0 += int'(pwm[0]); h1 += int'(pwm[1]);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 flag", int'(flag), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 pwm", int'(pwm), 0);
  endtask

  task automatic t_pwm();
    int h0, h1;
    wr(2'd1, 8'd4); wr(2'd2, 8'd2); wr(2'd3, 8'd3);
    set_ctrl(mk(1, 0, 2'b10, 2'b00));
    run = 1'b1;
    repeat (3) @(negedge clk);
    count_high(10, h0, h1);
    chk("R2 ch0 highs", h0, 4);
    chk("R2 ch1 highs", h1, 6);
    set_ctrl(mk(1, 0, 2'b10, 2'b01));
    count_high(10, h0, h1);
    chk("R3 inverted ch0 highs", h0, 6);
    set_ctrl(mk(1, 0, 2'b10, 2'b00));
    wr(2'd2, 8'd0);
    count_high(10, h0, h1);
    chk("R3 duty0 ch0 highs", h0, 0);
    wr(2'd2, 8'd2);
  endtask

  task automatic t_run_low();
    set_ctrl(mk(1, 0, 2'b10, 2'b01));
    run = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      chk("R4 idle while stopped", int'(pwm), 1);
      @(negedge clk);
    end
    set_ctrl(mk(1, 0, 2'b10, 2'b00));
    run = 1'b1;
    settle();
  endtask

  task automatic t_trip_rise();
    pins[0] = 1'b1;
    @(negedge clk);
    chk("R8 flag after 1 edge", int'(flag), 0);
    @(negedge clk);
    chk("R8 flag after 2 edges", int'(flag), 0);
    @(negedge clk);
    chk("R8 flag after 3 edges", int'(flag), 1);
    chk("R8 irq pulse", int'(irq), 1);
    chk("R9 both idle", int'(pwm), 0);
    @(negedge clk);
    chk("R8 irq single cycle", int'(irq), 0);
    repeat (5) begin
      chk("R9 held idle with run", int'(pwm), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_clear();
    wr(2'd0, cur_ctrl);
    chk("R10 write zero keeps flag", int'(flag), 1);
    clear_flag();
    chk("R10 flag cleared", int'(flag), 0);
    chk("R10 restart cnt0 ch0", int'(pwm[0]), 1);
    @(negedge clk);
    chk("R10 restart cnt1 ch0", int'(pwm[0]), 1);
    @(negedge clk);
    chk("R10 restart cnt2 ch0", int'(pwm[0]), 0);
    chk("R10 restart cnt2 ch1", int'(pwm[1]), 1);
  endtask

  task automatic t_edges();
    pins[0] = 1'b0; settle();
    chk("R5 rising mode ignores fall", int'(flag), 0);
    set_ctrl(mk(1, 0, 2'b01, 2'b00));
    pins[0] = 1'b1; settle();
    chk("R5 falling mode ignores rise", int'(flag), 0);
    pins[0] = 1'b0; settle();
    chk("R5 falling mode trips", int'(flag), 1);
    clear_flag();
    set_ctrl(mk(1, 0, 2'b11, 2'b00));
    pins[0] = 1'b1; settle();
    chk("R5 both mode rise", int'(flag), 1);
    clear_flag();
    pins[0] = 1'b0; settle();
    chk("R5 both mode fall", int'(flag), 1);
    clear_flag();
    set_ctrl(mk(1, 0, 2'b00, 2'b00));
    pins[0] = 1'b1; settle();
    pins[0] = 1'b0; settle();
    chk("R5 disabled no trip", int'(flag), 0);
  endtask

  task automatic t_select();
    set_ctrl(mk(1, 1, 2'b11, 2'b00));
    pins[0] = 1'b1; settle();
    chk("R6 unselected pin ignored", int'(flag), 0);
    pins[0] = 1'b0; settle();
    pins[1] = 1'b1; settle();
    chk("R6 selected pin1 trips", int'(flag), 1);
    clear_flag();
    pins[1] = 1'b0; settle();
    chk("R6 pin1 fall trips", int'(flag), 1);
    clear_flag();
  endtask

  task automatic t_pair_off();
    int h0, h1;
    int irqs = 0;
    set_ctrl(mk(0, 0, 2'b11, 2'b00));
    pins[0] = 1'b1;
    repeat (4) begin @(negedge clk); irqs += int'(irq); end
    pins[0] = 1'b0;
    repeat (4) begin @(negedge clk); irqs += int'(irq); end
    chk("R7 independent mode no flag", int'(flag), 0);
    chk("R7 independent mode no irq", irqs, 0);
    count_high(10, h0, h1);
    chk("R7 pwm keeps running", h0, 4);
  endtask

  task automatic t_same_cycle();
    set_ctrl(mk(1, 0, 2'b10, 2'b00));
    pins[0] = 1'b1; settle();
    chk("R11 first trip", int'(flag), 1);
    pins[0] = 1'b0; settle();
    pins[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clear_flag();
    chk("R11 trip beats clear", int'(flag), 1);
    chk("R11 irq on collision", int'(irq), 1);
    clear_flag();
    chk("R11 later clear works", int'(flag), 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_pwm();
    t_run_low();
    t_trip_rise();
    t_clear();
    t_edges();
    t_select();
    t_pair_off();
    t_same_cycle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule